// File: doc/BRIEF.md
# LF Telegram Transmit Sequencer

This block turns the contents of two alternating data buffers into a timed, amplitude-shift-keyed low-frequency telegram for an eight-channel antenna driver. It runs on a fast system clock and advances its timing only on a 2 MHz enable pulse. Each transmitted bit is held for a fixed number of enable pulses that depends on the selected bit rate. For every channel and every bit it issues a drive code for the output bridge and an amplitude selection for the sine amplifier that follows.

Software fills the buffers through write strobes. It chooses per channel whether the output is parked low, sends data at one of two carrier phases, or sends a short reduced-amplitude burst that cancels coupled energy. A raised-gain window of programmable position and length can be placed inside the telegram, and a busy status shows which buffer is on air. While one buffer is sent the other can be refilled, so the telegram continues across buffers. When no refill arrives in time, transmission stops by itself.

Top module: `lf_tx_sequencer`

## Requirements
- R1: Each buffer is sent most significant bit first, and `data_bit` shows the bit now on air (0 while idle).
- R2: A bit lasts 128 tick pulses when `rate_slow` is 0 and 256 when it is 1. The bit on air changes only on a clock edge at which `tick` is high.
- R3: A write to the buffer being sent is refused, and a write to the other buffer is accepted. At the end of a buffer, sending goes on with the other buffer if that buffer was written since it was last sent. Otherwise the block returns to idle.
- R4: A telegram always begins with buffer 1. With `auto_start`=1 it starts on the clock after a buffer-1 write takes effect. With `auto_start`=0 it needs a `start` pulse while buffer 1 holds unsent data, and a `start` pulse with buffer 1 empty is ignored.
- R5: `status` reads 00 when idle, 10 while buffer 1 is sent and 11 while buffer 2 is sent. It never reads 01.
- R6: Drive codes are 00 off (low side on), 01 mid-rail, 10 carrier 0°, 11 carrier 180°. Amplitude codes are 00 none, 01 gain1, 10 gain2, 11 destroy. When idle, and for every channel with mode 00, the drive is 00 and the amplitude is 00.
- R7: A channel in mode 10 (or mode 01) drives 10 (or 11) while the data bit is 1, and drives 01 while the data bit is 0.
- R8: Let t be the telegram bit index, B = `g2_start_bytes` and L = `g2_len_bits`. Data channels use amplitude 10 when 8·B ≤ t < 8·B+L and amplitude 01 otherwise, so L=0 never selects gain2.
- R9: A channel in mode 11 uses start S' = max(`dst_start_bits`, 2) and N = `dst_len`+1 bits. For t < S' it drives 01 with amplitude 00. For S' ≤ t < S'+N it drives 10 with amplitude 11. After that it drives 00 with amplitude 00.
- R10: The telegram bit index t counts from the first bit of buffer 1 and keeps counting across buffer swaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 2 MHz timing enable |
| rate_slow | input | 1 | 1 selects the slow bit rate |
| auto_start | input | 1 | 1 starts as soon as buffer 1 is loaded |
| ch_mode | input | 2*NCH | Per-channel mode, channel i in bits [2i+1:2i] |
| g2_start_bytes | input | 6 | Gain2 window start in bytes |
| g2_len_bits | input | 7 | Gain2 window length in bits |
| dst_start_bits | input | 6 | Destroy burst start in bits |
| dst_len | input | 2 | Destroy burst length minus one |
| wr_buf1 | input | 1 | Write strobe for buffer 1 |
| wr_buf2 | input | 1 | Write strobe for buffer 2 |
| wr_data | input | BUF_W | Buffer write data |
| start | input | 1 | Start pulse for manual mode |
| status | output | 2 | Idle / sending buffer 1 / sending buffer 2 |
| data_bit | output | 1 | Bit currently on air |
| ch_drive | output | 2*NCH | Per-channel drive code |
| ch_amp | output | 2*NCH | Per-channel amplitude select |

## Verification
The hardest case is a telegram that crosses a buffer boundary while the gain2 window is open and a write to the active buffer is attempted. That situation needs a refill of the idle buffer at the right moment during a long run. The bench builds a model of the bit index from the tick pulses it has issued since the start edge. It issues the refused write and the refill at fixed bit positions taken from that count, and then checks every output on every cycle against the arithmetic model. A sweep over the destroy start, the destroy length and the gain2 window then covers the clamped start values 0 and 1 and a zero-length window.

// File: rtl/lf_tx_sequencer.sv
module lf_tx_sequencer #(
  parameter int BUF_W      = 56,
  parameter int NCH        = 8,
  parameter int TICKS_FAST = 128,
  parameter int TICKS_SLOW = 256,
  parameter int TEL_W      = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rate_slow,
  input  logic               auto_start,
  input  logic [2*NCH-1:0]   ch_mode,
  input  logic [5:0]         g2_start_bytes,
  input  logic [6:0]         g2_len_bits,
  input  logic [5:0]         dst_start_bits,
  input  logic [1:0]         dst_len,
  input  logic               wr_buf1,
  input  logic               wr_buf2,
  input  logic [BUF_W-1:0]   wr_data,
  input  logic               start,
  output logic [1:0]         status,
  output logic               data_bit,
  output logic [2*NCH-1:0]   ch_drive,
  output logic [2*NCH-1:0]   ch_amp
);
  localparam int CW = $clog2(TICKS_SLOW);
  localparam int IW = $clog2(BUF_W);
  localparam logic [TEL_W-1:0] TEL_MAX = '1;

  logic [BUF_W-1:0] buf1_q, buf2_q;
  logic             full1, full2;
  logic             busy, cur;
  logic [CW-1:0]    tcnt;
  logic [IW-1:0]    bidx;
  logic [TEL_W-1:0] tel;

  logic tick_last, buf_last, go, other_full;
  logic [TEL_W-1:0] g2_lo, g2_hi, d_lo, d_hi;
  logic in_g2, pre_d, in_d;

  assign tick_last  = tcnt == (rate_slow ? CW'(TICKS_SLOW-1) : CW'(TICKS_FAST-1));
  assign buf_last   = bidx == IW'(BUF_W-1);
  assign go         = !busy && full1 && (auto_start || start);
  assign other_full = cur ? full1 : full2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf1_q <= '0;
      buf2_q <= '0;
      full1  <= 1'b0;
      full2  <= 1'b0;
      busy   <= 1'b0;
      cur    <= 1'b0;
      tcnt   <= '0;
      bidx   <= '0;
      tel    <= '0;
    end else begin
      if (wr_buf1 && !(busy && !cur)) begin
        buf1_q <= wr_data;
        full1  <= 1'b1;
      end
      if (wr_buf2 && !(busy && cur)) begin
        buf2_q <= wr_data;
        full2  <= 1'b1;
      end
      if (go) begin
        busy <= 1'b1;
        cur  <= 1'b0;
        tcnt <= '0;
        bidx <= '0;
        tel  <= '0;
      end else if (busy && tick) begin
        if (tick_last) begin
          tcnt <= '0;
          if (tel != TEL_MAX) tel <= tel + 1'b1;
          if (buf_last) begin
            bidx <= '0;
            if (cur) full2 <= 1'b0;
            else     full1 <= 1'b0;
            if (other_full) cur  <= ~cur;
            else            busy <= 1'b0;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign status   = busy ? {1'b1, cur} : 2'b00;
  assign data_bit = busy & (cur ? buf2_q[BUF_W-1-int'(bidx)] : buf1_q[BUF_W-1-int'(bidx)]);

  assign g2_lo = TEL_W'({g2_start_bytes, 3'b000});
  assign g2_hi = g2_lo + TEL_W'(g2_len_bits);
  assign in_g2 = (g2_len_bits != 7'd0) && (tel >= g2_lo) && (tel < g2_hi);

  assign d_lo  = (dst_start_bits < 6'd2) ? TEL_W'(2) : TEL_W'(dst_start_bits);
  assign d_hi  = d_lo + TEL_W'(dst_len) + 1'b1;
  assign pre_d = tel < d_lo;
  assign in_d  = !pre_d && (tel < d_hi);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      ch_drive[2*i +: 2] = 2'b00;
      ch_amp[2*i +: 2]   = 2'b00;
      if (busy) begin
        case (ch_mode[2*i +: 2])
          2'b01: begin
            ch_drive[2*i +: 2] = data_bit ? 2'b11 : 2'b01;
            ch_amp[2*i +: 2]   = in_g2 ? 2'b10 : 2'b01;
          end
          2'b10: begin
            ch_drive[2*i +: 2] = data_bit ? 2'b10 : 2'b01;
            ch_amp[2*i +: 2]   = in_g2 ? 2'b10 : 2'b01;
          end
          2'b11: begin
            if (pre_d) begin
              ch_drive[2*i +: 2] = 2'b01;
            end else if (in_d) begin
              ch_drive[2*i +: 2] = 2'b10;
              ch_amp[2*i +: 2]   = 2'b11;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lf_tx_sequencer_chk.sv
module lf_tx_sequencer_chk #(
  parameter int NCH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [2*NCH-1:0] ch_mode,
  input logic [6:0]       g2_len_bits,
  input logic [1:0]       status,
  input logic             data_bit,
  input logic [2*NCH-1:0] ch_drive,
  input logic [2*NCH-1:0] ch_amp
);
  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] || !status[0]);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> (ch_drive == '0) && (ch_amp == '0));

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !tick) |=> status[1] && $stable(data_bit) && $stable(status));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_parked_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[2*i +: 2] == 2'b00) |-> (ch_drive[2*i +: 2] == 2'b00) && (ch_amp[2*i +: 2] == 2'b00));

    assert_zero_bit_midrail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && !data_bit && ch_mode[2*i] != ch_mode[2*i+1]) |-> ch_drive[2*i +: 2] == 2'b01);

    assert_no_gain2_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (g2_len_bits == 7'd0) |-> ch_amp[2*i +: 2] != 2'b10);
  end
endmodule

bind lf_tx_sequencer lf_tx_sequencer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ch_mode(ch_mode), .g2_len_bits(g2_len_bits),
  .status(status), .data_bit(data_bit), .ch_drive(ch_drive), .ch_amp(ch_amp)
);

// File: tb/sim_lf_tx_sequencer.sv
module sim_lf_tx_sequencer;
  localparam int W = 16, NCH = 8, TF = 8, TS = 16;

  logic clk = 0, rst_n = 0, tick = 0;
  logic rate_slow = 0, auto_start = 0, wr_buf1 = 0, wr_buf2 = 0, start = 0;
  logic [2*NCH-1:0] ch_mode = '0;
  logic [5:0] g2_start_bytes = 0, dst_start_bits = 0;
  logic [6:0] g2_len_bits = 0;
  logic [1:0] dst_len = 0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] status;
  logic data_bit;
  logic [2*NCH-1:0] ch_drive, ch_amp;

  lf_tx_sequencer #(.BUF_W(W), .NCH(NCH), .TICKS_FAST(TF), .TICKS_SLOW(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_slow(rate_slow), .auto_start(auto_start),
    .ch_mode(ch_mode), .g2_start_bytes(g2_start_bytes), .g2_len_bits(g2_len_bits),
    .dst_start_bits(dst_start_bits), .dst_len(dst_len), .wr_buf1(wr_buf1), .wr_buf2(wr_buf2),
    .wr_data(wr_data), .start(start), .status(status), .data_bit(data_bit),
    .ch_drive(ch_drive), .ch_amp(ch_amp));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, n = 0, nb = 0;
  bit arm = 0, tracking = 0, done = 0;
  logic [W-1:0] exp_buf [0:3];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s: actual=%0d expected=%0d (n=%0d)", req, act, exp, n);
    end
  endtask

  function automatic int exp_ch(input logic [1:0] m, input bit db, input int t);
    int lo, hi, dl, dh, d, a;
    lo = 8 * g2_start_bytes; hi = lo + g2_len_bits;
    dl = (dst_start_bits < 2) ? 2 : int'(dst_start_bits); dh = dl + dst_len + 1;
    d = 0; a = 0;
    case (m)
      2'b01: begin d = db ? 3 : 1; a = (t >= lo && t < hi) ? 2 : 1; end
      2'b10: begin d = db ? 2 : 1; a = (t >= lo && t < hi) ? 2 : 1; end
      2'b11: begin
        if (t < dl) d = 1;
        else if (t < dh) begin d = 2; a = 3; end
      end
      default: ;
    endcase
    return d * 4 + a;
  endfunction

  always @(negedge clk) begin
    if (arm) begin
      arm = 0; tracking = 1; n = 0;
    end else if (tracking && tick) n++;
    if (tracking) begin
      int p, t;
      p = rate_slow ? TS : TF;
      t = n / p;
      if (t < nb * W) begin
        bit db;
        db = exp_buf[t / W][W - 1 - (t % W)];
        check("R5 status", status, 2 + ((t / W) % 2));
        check("R1/R3 data_bit", data_bit, db);
        for (int c = 0; c < NCH; c++) begin
          int e;
          e = exp_ch(ch_mode[2*c +: 2], db, t);
          check("R7/R9/R10 drive", ch_drive[2*c +: 2], e / 4);
          check("R8/R9 amp", ch_amp[2*c +: 2], e % 4);
        end
      end else begin
        check("R3 stop status", status, 0);
        check("R6 idle drive", ch_drive, 0);
        check("R6 idle amp", ch_amp, 0);
        tracking = 0;
      end
    end
    tick = ~tick;
  end

  task automatic at_edge; @(posedge clk); #2; endtask

  task automatic write(input bit which, input logic [W-1:0] d);
    at_edge; wr_data = d; wr_buf1 = !which; wr_buf2 = which;
    at_edge; wr_buf1 = 0; wr_buf2 = 0;
  endtask

  task automatic pulse_start_armed;
    at_edge; start = 1;
    at_edge; start = 0; arm = 1;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (tracking || arm) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ch_mode = {2'b11, 2'b01, 2'b10, 2'b11, 2'b11, 2'b00, 2'b01, 2'b10};
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check("R5 reset status", status, 0);
    check("R1 reset data_bit", data_bit, 0);
    check("R6 reset drive", ch_drive, 0);
    check("R6 reset amp", ch_amp, 0);

    // R4: start with empty buffer 1 is ignored; manual mode waits for start
    at_edge; start = 1; at_edge; start = 0;
    repeat (4) @(negedge clk);
    check("R4 start without data", status, 0);
    write(1'b0, 16'hA5C3);
    repeat (10) @(negedge clk);
    check("R4 manual waits", status, 0);
    exp_buf[0] = 16'hA5C3; nb = 1;
    g2_start_bytes = 0; g2_len_bits = 3; dst_start_bits = 4; dst_len = 1;
    pulse_start_armed; wait_idle;

    // R3/R10: telegram over three buffers, refused write, gain2 across swap
    g2_start_bytes = 1; g2_len_bits = 20; dst_start_bits = 20; dst_len = 3;
    write(1'b0, 16'h9E31); write(1'b1, 16'h4C7B);
    exp_buf[0] = 16'h9E31; exp_buf[1] = 16'h4C7B; exp_buf[2] = 16'hD20F; nb = 3;
    pulse_start_armed;
    while (n < 3 * TF + 2) @(negedge clk);
    write(1'b0, 16'hFFFF);
    while (n < (W + 4) * TF) @(negedge clk);
    write(1'b0, 16'hD20F);
    wait_idle;

    // R2: slow rate, auto start, single buffer
    rate_slow = 1; auto_start = 1; g2_start_bytes = 0; g2_len_bits = 0;
    dst_start_bits = 1; dst_len = 2;
    exp_buf[0] = 16'h36E9; nb = 1;
    write(1'b0, 16'h36E9); at_edge; arm = 1; wait_idle;
    rate_slow = 0;

    // R8/R9 sweep: destroy start incl. clamped values, lengths, gain2 windows
    for (int ds = 0; ds < 6; ds++) begin
      for (int dl = 0; dl < 4; dl++) begin
        logic [W-1:0] pat;
        pat = W'(16'h1357 * (ds * 4 + dl + 1) ^ 16'hB6D4);
        dst_start_bits = 6'(ds); dst_len = 2'(dl);
        g2_start_bytes = 6'(ds % 2); g2_len_bits = 7'(dl * 3);
        exp_buf[0] = pat; nb = 1;
        write(1'b0, pat); at_edge; arm = 1; wait_idle;
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule